// File: doc/BRIEF.md
# Job-Slot Interrupt and Status Controller

This block gathers completion and failure events from sixteen job slots into one set of interrupt registers and drives a single interrupt line toward the host. Software enables individual sources with a mask, reads the raw and masked views, and acknowledges events by writing ones to a clear register.

Acknowledging an event also refreshes a per-slot state snapshot. The slots named by either half of the written clear word get their active and queued-next flags sampled into the snapshot register. Every other slot keeps the snapshot bits it already had.

The register port is a simple 32-bit read/write interface with a 12-bit byte address. Accesses at or above byte address 0x800 are not decoded here. They are passed to an external per-slot register port, along with a slot index and a slot-local offset. Reset clears the interrupt state and raises a reset toward all sixteen slots.

Top module: `jsirq_ctrl`

## Requirements
- R1: A one-cycle pulse on `done_i[n]` sets raw interrupt bit n on the next clock edge.
- R2: A one-cycle pulse on `fail_i[n]` sets raw interrupt bit 16+n on the next clock edge.
- R3: Reading the status register returns raw AND mask. `irq_o` is high exactly when that value is nonzero. A write to the mask register replaces the whole mask.
- R4: Writing the clear register clears every raw bit where the written word has a 1. Reading the clear register returns zero.
- R5: When an event sets a raw bit in the same cycle that a clear write clears it, the bit ends up set.
- R6: Writes to the raw register and to the status register change no stored state.
- R7: On a clear write, the affected slot set is wdata[15:0] OR wdata[31:16]. For each affected slot n, snapshot bit n takes `active_i[n]` and snapshot bit 16+n takes `queued_i[n]`, both sampled in the write cycle.
- R8: Snapshot bits of slots outside the affected set keep their previous values across a clear write.
- R9: An access at address 0x800 or above drives `slot_wr`/`slot_rd` with slot index addr[10:7], offset addr[6:0] and the write data. Such an access leaves the interrupt registers untouched, and a read there returns `slot_rdata`.
- R10: After reset, raw, mask and snapshot are zero and `irq_o` is low. `slot_rst_o` has all 16 bits high while reset is held and for the first clock edge after release, and is low from then on.
- R11: The interrupt register offsets are raw 0x000, clear 0x004, mask 0x008, status 0x00C and snapshot 0x010. Any other address below 0x800 reads as zero and does not assert `slot_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| done_i | input | 16 | Per-slot job-done pulses |
| fail_i | input | 16 | Per-slot job-failed pulses |
| active_i | input | 16 | Per-slot active-job flags |
| queued_i | input | 16 | Per-slot queued-next-job flags |
| irq_o | output | 1 | Interrupt request |
| slot_wr | output | 1 | Forwarded write strobe to the slot register port |
| slot_rd | output | 1 | Forwarded read strobe to the slot register port |
| slot_idx | output | 4 | Decoded slot number |
| slot_off | output | 7 | Slot-local byte offset |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Read data returned by the slot register port |
| slot_rst_o | output | 16 | Reset request to each slot |

## Verification
The hardest state to reach is a snapshot that holds bits sampled at different times. This happens when one slot's flags are captured, the flags then change, and a later clear names only other slots. The stimulus builds this in steps. It captures slot 3 and then slot 5 with separate clear writes, drops the active flags, and then clears only slot 2. The stale slot-3 bit must survive that last write. A separate case pulses a done event in the very cycle that a clear write names the same bit, to confirm that the event takes priority.

// File: rtl/jsirq_pkg.sv
package jsirq_pkg;
    localparam int NSLOT      = 16;
    localparam int DW         = 32;
    localparam int AW         = 12;
    localparam int SLOT_SHIFT = 7;
    localparam int IDXW       = $clog2(NSLOT);
    localparam int OFFW       = SLOT_SHIFT;

    localparam logic [AW-1:0] OFF_RAW   = 12'h000;
    localparam logic [AW-1:0] OFF_CLR   = 12'h004;
    localparam logic [AW-1:0] OFF_MASK  = 12'h008;
    localparam logic [AW-1:0] OFF_STAT  = 12'h00C;
    localparam logic [AW-1:0] OFF_SNAP  = 12'h010;
    localparam logic [AW-1:0] SLOT_BASE = 12'h800;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_CLR,
        SEL_MASK,
        SEL_STAT,
        SEL_SNAP,
        SEL_SLOT
    } sel_e;

    typedef struct packed {
        logic [DW-1:0] raw;
        logic [DW-1:0] mask;
    } irq_state_t;
endpackage

// File: rtl/jsirq_decode.sv
module jsirq_decode
    import jsirq_pkg::*;
(
    input  logic [AW-1:0]   addr,
    output sel_e            sel,
    output logic [IDXW-1:0] idx,
    output logic [OFFW-1:0] off
);
    always_comb begin
        if (addr >= SLOT_BASE) begin
            sel = SEL_SLOT;
        end else begin
            case (addr)
                OFF_RAW:  sel = SEL_RAW;
                OFF_CLR:  sel = SEL_CLR;
                OFF_MASK: sel = SEL_MASK;
                OFF_STAT: sel = SEL_STAT;
                OFF_SNAP: sel = SEL_SNAP;
                default:  sel = SEL_NONE;
            endcase
        end
        idx = addr[SLOT_SHIFT +: IDXW];
        off = addr[OFFW-1:0];
    end
endmodule

// File: rtl/jsirq_irq.sv
module jsirq_irq
    import jsirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [DW-1:0]    wdata,
    input  logic [NSLOT-1:0] done,
    input  logic [NSLOT-1:0] fail,
    output logic [DW-1:0]    raw_q,
    output logic [DW-1:0]    mask_q,
    output logic [DW-1:0]    status,
    output logic             irq
);
    irq_state_t st_d, st_q;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        set_bits = {fail, done};
        st_d      = st_q;
        st_d.raw  = (st_q.raw & ~clr_bits) | set_bits;
        if (mask_we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign status = st_q.raw & st_q.mask;
    assign irq    = |status;
endmodule

// File: rtl/jsirq_snap.sv
module jsirq_snap
    import jsirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [DW-1:0]    wdata,
    input  logic [NSLOT-1:0] active,
    input  logic [NSLOT-1:0] queued,
    output logic [DW-1:0]    snap_q
);
    logic [DW-1:0]    snap_d;
    logic [NSLOT-1:0] hit;

    always_comb begin
        hit    = clr_we ? (wdata[NSLOT-1:0] | wdata[DW-1:NSLOT]) : '0;
        snap_d = snap_q;
        for (int n = 0; n < NSLOT; n++) begin
            if (hit[n]) begin
                snap_d[n]         = active[n];
                snap_d[NSLOT + n] = queued[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end
endmodule

// File: rtl/jsirq_ctrl.sv
module jsirq_ctrl
    import jsirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NSLOT-1:0] done_i,
    input  logic [NSLOT-1:0] fail_i,
    input  logic [NSLOT-1:0] active_i,
    input  logic [NSLOT-1:0] queued_i,
    output logic             irq_o,
    output logic             slot_wr,
    output logic             slot_rd,
    output logic [IDXW-1:0]  slot_idx,
    output logic [OFFW-1:0]  slot_off,
    output logic [DW-1:0]    slot_wdata,
    input  logic [DW-1:0]    slot_rdata,
    output logic [NSLOT-1:0] slot_rst_o
);
    sel_e          sel;
    logic          clr_we;
    logic          mask_we;
    logic [DW-1:0] raw_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] status;
    logic [DW-1:0] snap_q;
    logic          srst_d, srst_q;

    jsirq_decode u_dec (
        .addr (reg_addr),
        .sel  (sel),
        .idx  (slot_idx),
        .off  (slot_off)
    );

    assign clr_we  = reg_wr && (sel == SEL_CLR);
    assign mask_we = reg_wr && (sel == SEL_MASK);

    jsirq_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_we  (clr_we),
        .mask_we (mask_we),
        .wdata   (reg_wdata),
        .done    (done_i),
        .fail    (fail_i),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .status  (status),
        .irq     (irq_o)
    );

    jsirq_snap u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_we (clr_we),
        .wdata  (reg_wdata),
        .active (active_i),
        .queued (queued_i),
        .snap_q (snap_q)
    );

    assign slot_wr    = reg_wr && (sel == SEL_SLOT);
    assign slot_rd    = reg_rd && (sel == SEL_SLOT);
    assign slot_wdata = reg_wdata;

    always_comb begin
        case (sel)
            SEL_RAW:  reg_rdata = raw_q;
            SEL_MASK: reg_rdata = mask_q;
            SEL_STAT: reg_rdata = status;
            SEL_SNAP: reg_rdata = snap_q;
            SEL_SLOT: reg_rdata = slot_rdata;
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        srst_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q <= 1'b1;
        end else begin
            srst_q <= srst_d;
        end
    end

    assign slot_rst_o = {NSLOT{srst_q}};
endmodule

// File: rtl/jsirq_chk.sv
module jsirq_chk
    import jsirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [NSLOT-1:0] done_i,
    input logic [NSLOT-1:0] fail_i,
    input logic             slot_wr,
    input logic             irq_o,
    input logic [DW-1:0]    raw_q,
    input logic [DW-1:0]    mask_q,
    input logic [DW-1:0]    snap_q
);
    logic            clr_wr;
    logic [DW-1:0]   keep_mask;
    assign clr_wr    = reg_wr && (reg_addr == OFF_CLR);
    assign keep_mask = ~{reg_wdata[NSLOT-1:0] | reg_wdata[DW-1:NSLOT],
                         reg_wdata[NSLOT-1:0] | reg_wdata[DW-1:NSLOT]};

    // R1
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((raw_q[NSLOT-1:0] & $past(done_i)) == $past(done_i)));

    // R2
    fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fail_i) |=> ((raw_q[DW-1:NSLOT] & $past(fail_i)) == $past(fail_i)));

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (&reg_wdata) && !(|done_i) && !(|fail_i)) |=> !irq_o);

    // R6
    raw_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFF_RAW || reg_addr == OFF_STAT)
         && !(|done_i) && !(|fail_i)) |=> ($stable(raw_q) && $stable(mask_q)));

    // R8
    snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((snap_q & $past(keep_mask)) == ($past(snap_q) & $past(keep_mask))));

    // R9
    route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= SLOT_BASE) |-> slot_wr);

    // R9
    route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= SLOT_BASE) |=> $stable(mask_q));
endmodule

bind jsirq_ctrl jsirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done_i    (done_i),
    .fail_i    (fail_i),
    .slot_wr   (slot_wr),
    .irq_o     (irq_o),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .snap_q    (snap_q)
);

// File: tb/sim_jsirq_ctrl.sv
module sim_jsirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] done_i = '0;
    logic [15:0] fail_i = '0;
    logic [15:0] active_i = '0;
    logic [15:0] queued_i = '0;
    logic        irq_o;
    logic        slot_wr;
    logic        slot_rd;
    logic [3:0]  slot_idx;
    logic [6:0]  slot_off;
    logic [31:0] slot_wdata;
    logic [31:0] slot_rdata = 32'hCAFE_F00D;
    logic [15:0] slot_rst_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    jsirq_ctrl u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] d, input logic [15:0] f);
        @(posedge clk); #1;
        done_i = d; fail_i = f;
        @(posedge clk); #1;
        done_i = '0; fail_i = '0;
    endtask

    // scoreboard monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rst_n && reg_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected read actual=%h expected=none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 slot_rst held", {16'h0, slot_rst_o}, 32'h0000_FFFF);
        check("R10 irq in reset", {31'h0, irq_o}, 32'h0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R10 slot_rst first cycle", {16'h0, slot_rst_o}, 32'h0000_FFFF);
        @(negedge clk);
        check("R10 slot_rst released", {16'h0, slot_rst_o}, 32'h0);
        rd(12'h000, 32'h0, "R10 raw reset");
        rd(12'h008, 32'h0, "R10 mask reset");
        rd(12'h010, 32'h0, "R10 snap reset");

        pulse(16'h0008, 16'h0020);
        rd(12'h000, 32'h0020_0008, "R1 R2 raw after events");
        rd(12'h00C, 32'h0, "R3 status mask zero");
        check("R3 irq low mask zero", {31'h0, irq_o}, 32'h0);
        wr(12'h008, 32'h0000_0008);
        rd(12'h00C, 32'h0000_0008, "R3 status masked");
        check("R3 irq high", {31'h0, irq_o}, 32'h1);

        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h0020_0008, "R6 raw write ignored");
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h008, 32'h0000_0008, "R6 status write ignored");
        rd(12'h004, 32'h0, "R4 clear reads zero");

        active_i = 16'h000F; queued_i = 16'h0030;
        wr(12'h004, 32'h0000_0008);
        rd(12'h000, 32'h0020_0000, "R4 clear bit3");
        check("R3 irq after clear", {31'h0, irq_o}, 32'h0);
        rd(12'h010, 32'h0000_0008, "R7 snap slot3");
        wr(12'h004, 32'h0020_0000);
        rd(12'h000, 32'h0, "R4 clear upper");
        rd(12'h010, 32'h0020_0008, "R7 snap slot5 queued");
        active_i = 16'h0000;
        wr(12'h004, 32'h0000_0004);
        rd(12'h010, 32'h0020_0008, "R8 other slots kept");
        active_i = 16'h0001; queued_i = 16'h0002;
        wr(12'h004, 32'h0001_0002);
        rd(12'h010, 32'h0022_0009, "R7 union of halves");

        pulse(16'h0080, 16'h0);
        rd(12'h000, 32'h0000_0080, "R1 done bit7");
        @(posedge clk); #1;
        done_i = 16'h0080; reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h0000_0080;
        @(posedge clk); #1;
        done_i = '0; reg_wr = 1'b0;
        rd(12'h000, 32'h0000_0080, "R5 event beats clear");
        @(posedge clk); #1;
        done_i = 16'h0100; reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        done_i = '0; reg_wr = 1'b0;
        rd(12'h000, 32'h0000_0100, "R5 clear all with new event");
        rd(12'h010, 32'h0002_0001, "R7 all slots refreshed");
        wr(12'h008, 32'h0000_0100);
        check("R3 irq mask replaced", {31'h0, irq_o}, 32'h1);
        wr(12'h004, 32'hFFFF_FFFF);
        check("R4 irq after clear all", {31'h0, irq_o}, 32'h0);

        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 12'hA94; reg_wdata = 32'h1234_5678;
        @(negedge clk);
        check("R9 slot_wr", {31'h0, slot_wr}, 32'h1);
        check("R9 slot_idx", {28'h0, slot_idx}, 32'h5);
        check("R9 slot_off", {25'h0, slot_off}, 32'h14);
        check("R9 slot_wdata", slot_wdata, 32'h1234_5678);
        @(posedge clk); #1;
        reg_wr = 1'b0;
        rd(12'h008, 32'h0000_0100, "R9 mask untouched");
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 12'h808; reg_wdata = 32'h0000_0000;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        rd(12'h008, 32'h0000_0100, "R9 slot write at mask offset");
        exp_q.push_back(32'hCAFE_F00D);
        tag_q.push_back("R9 slot read data");
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = 12'hFFC;
        @(negedge clk);
        check("R9 slot_rd", {31'h0, slot_rd}, 32'h1);
        check("R9 slot_idx 15", {28'h0, slot_idx}, 32'hF);
        check("R9 slot_off 7c", {25'h0, slot_off}, 32'h7C);
        @(posedge clk); #1;
        reg_rd = 1'b0;
        exp_q.push_back(32'h0);
        tag_q.push_back("R11 unmapped low read");
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = 12'h7FC;
        @(negedge clk);
        check("R11 no slot_rd below base", {31'h0, slot_rd}, 32'h0);
        @(posedge clk); #1;
        reg_rd = 1'b0;

        repeat (3) @(posedge clk);
        check("R11 scoreboard drained", exp_q.size(), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule